// File: doc/BRIEF.md
# SPI-Driven Multiplexer Port Expander

This block sits between a microcontroller acting as SPI master and sixteen plug-in submodules. Each submodule carries three 16-channel multiplexers: one fans a single line out to digital outputs, one gathers digital inputs onto a single line, and one routes analog inputs toward a shared converter. Every full-duplex 16-bit SPI word moves one channel's worth of data for all sixteen modules at once. Bit i of the incoming word goes to output module i. Bit i of the outgoing word reports input module i.

The digital multiplexers share a 4-bit channel address that follows a count of completed words. Sixteen words therefore refresh every digital channel. An analog scan runs alongside. Each completed word moves the analog select to the next channel, and after sixteen channels it moves on to the next analog module, which is enabled through a one-hot line. A 2-bit configuration field limits the analog scan to 4, 8, 12 or 16 modules. A synchronous scan-reset input returns both sequences to channel 0, and the configuration field is captured only while that input is high.

All SPI pins are oversampled in the system clock domain. The SPI clock must therefore be several times slower than the system clock.

Top module: `spi_mux_expander`

## Requirements
- R1: SPI transfers use mode 0, most significant bit first. The master shifts data in on SPI clock rising edges while chip-select is low. A word is complete at the 16th rising edge.
- R2: During a transaction, the word shifted out on `spi_miso` equals `din_line` as seen at the digital address of that transaction. Bit 15 is sent first, and bit i is input module i.
- R3: When a transaction starts (chip-select falls), `dig_sel` takes the number of words completed since scan reset, modulo 16. The count advances by one per completed word and wraps from 15 to 0.
- R4: `dout_line` is cleared when a transaction starts. It is loaded with the received word (bit i drives output module i) when the word completes, and holds that value until the next transaction starts.
- R5: If chip-select rises before 16 rising edges, the word count does not advance and `dout_line` is not loaded. The next full word uses the same channel.
- R6: While `scan_rst` is high, the word count, `dig_sel`, `dout_line`, `ana_sel` and the analog module index are cleared. The first word afterwards uses channel 0 and returns the inputs of channel 0.
- R7: Each completed word advances `ana_sel` by one, modulo 16. `ana_sel` changes at no other time except a scan reset.
- R8: When `ana_sel` wraps from 15 to 0, the analog module index advances by one. The index wraps to 0 after the last enabled module.
- R9: `ana_en` has exactly one bit set, the bit of the active analog module.
- R10: `scan_cfg` is captured while `scan_rst` is high. Values 0, 1, 2 and 3 enable 4, 8, 12 and 16 analog modules respectively.
- R11: Changes on `scan_cfg` while `scan_rst` is low have no effect on the analog scan length.
- R12: After `rst_n`, the block starts at channel 0, module 0 (`ana_en` = 1), with `dout_line` = 0 and all 16 analog modules enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_rst | input | 1 | Synchronous scan reset, active high; also captures `scan_cfg` |
| scan_cfg | input | 2 | Analog scan length select (4, 8, 12 or 16 modules) |
| spi_sclk | input | 1 | SPI clock from the master |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | SPI data from the master |
| spi_miso | output | 1 | SPI data to the master |
| dout_line | output | 16 | Common lines of the sixteen output multiplexers |
| din_line | input | 16 | Common lines of the sixteen input multiplexers |
| dig_sel | output | 4 | Shared channel address of all digital multiplexers |
| ana_sel | output | 4 | Channel address of the analog multiplexers |
| ana_en | output | 16 | One-hot enable of the active analog module |

## Verification
The assertions assume that `scan_rst` is synchronous to `clk`. They also assume that each SPI clock level and each chip-select level lasts long enough for the two-stage synchronizer to see every edge, so that a word start and a word completion never arrive in the same cycle. The bench keeps to this by holding each SPI clock phase for four system clocks and by leaving a long idle gap between transactions. `din_line` is modelled as a fixed function of `dig_sel`. The bench samples `spi_miso` only after the settle delay that follows each change of address.

// File: rtl/pxp_pkg.sv
package pxp_pkg;

  // word boundary events produced by the SPI front end
  typedef struct packed {
    logic start;  // chip-select went low
    logic done;   // a full word was received
  } word_evt_t;

  // number of analog modules scanned for a configuration code
  function automatic int unsigned scan_limit(input logic [1:0] cfg,
                                             input int unsigned mods);
    return (32'(cfg) + 32'd1) * (mods / 32'd4);
  endfunction

endpackage

// File: rtl/pxp_spi_word.sv
module pxp_spi_word
  import pxp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         mosi,
  output logic         miso,
  input  logic         tx_load,
  input  logic [W-1:0] tx_data,
  output word_evt_t    evt,
  output logic [W-1:0] rx_word
);

  localparam int BCW = $clog2(W);

  // synchronizer stages: bit0 sclk, bit1 cs_n, bit2 mosi
  logic [2:0]     sync1_q, sync2_q;
  logic           sclk_q, cs_q;
  logic [BCW-1:0] bit_q, bit_n;
  logic [W-1:0]   rx_q, rx_n;
  logic [W-1:0]   tx_q, tx_n;
  logic [W-1:0]   rxw_q, rxw_n;
  logic           done_q, done_n;
  logic           start_q, start_n;
  logic           sclk_rise, sclk_fall, cs_lo, cs_fall;

  always_comb begin
    sclk_rise = sync2_q[0] & ~sclk_q;
    sclk_fall = ~sync2_q[0] & sclk_q;
    cs_lo     = ~sync2_q[1];
    cs_fall   = cs_lo & cs_q;

    bit_n   = bit_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    rxw_n   = rxw_q;
    done_n  = 1'b0;
    start_n = cs_fall;

    if (!cs_lo) begin
      bit_n = '0;
    end else if (sclk_rise) begin
      rx_n  = {rx_q[W-2:0], sync2_q[2]};
      bit_n = BCW'(bit_q + 1'b1);
      if (bit_q == BCW'(W - 1)) begin
        done_n = 1'b1;
        rxw_n  = rx_n;
      end
    end

    if (tx_load) begin
      tx_n = tx_data;
    end else if (cs_lo && sclk_fall) begin
      tx_n = {tx_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 3'b010;
      sync2_q <= 3'b010;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      rxw_q   <= '0;
      done_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      sync1_q <= {mosi, cs_n, sclk};
      sync2_q <= sync1_q;
      sclk_q  <= sync2_q[0];
      cs_q    <= sync2_q[1];
      bit_q   <= bit_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      rxw_q   <= rxw_n;
      done_q  <= done_n;
      start_q <= start_n;
    end
  end

  assign miso      = tx_q[W-1];
  assign evt.start = start_q;
  assign evt.done  = done_q;
  assign rx_word   = rxw_q;

endmodule

// File: rtl/pxp_dig_seq.sv
module pxp_dig_seq
  import pxp_pkg::*;
#(
  parameter int W      = 16,
  parameter int CH     = 16,
  parameter int SETTLE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scan_rst,
  input  word_evt_t              evt,
  input  logic [W-1:0]           rx_word,
  input  logic [W-1:0]           din_line,
  output logic [$clog2(CH)-1:0]  dig_sel,
  output logic [W-1:0]           dout_line,
  output logic                   tx_load,
  output logic [W-1:0]           tx_data
);

  localparam int CHW = $clog2(CH);
  localparam int SW  = $clog2(SETTLE + 1);

  logic [CHW-1:0] cnt_q, cnt_n;
  logic [CHW-1:0] sel_q, sel_n;
  logic [W-1:0]   out_q, out_n;
  logic [SW-1:0]  set_q, set_n;

  always_comb begin
    cnt_n = cnt_q;
    sel_n = sel_q;
    out_n = out_q;
    set_n = set_q;
    if (scan_rst) begin
      cnt_n = '0;
      sel_n = '0;
      out_n = '0;
      set_n = '0;
    end else begin
      if (evt.start) begin
        sel_n = cnt_q;
        out_n = '0;
        set_n = SW'(SETTLE);
      end else if (set_q != '0) begin
        set_n = SW'(set_q - 1'b1);
      end
      if (evt.done) begin
        out_n = rx_word;
        cnt_n = (cnt_q == CHW'(CH - 1)) ? '0 : CHW'(cnt_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
      out_q <= '0;
      set_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      sel_q <= sel_n;
      out_q <= out_n;
      set_q <= set_n;
    end
  end

  // input commons are captured once the new address has settled
  assign tx_load   = (set_q == SW'(1)) & ~scan_rst;
  assign tx_data   = din_line;
  assign dig_sel   = sel_q;
  assign dout_line = out_q;

endmodule

// File: rtl/pxp_ana_seq.sv
module pxp_ana_seq
  import pxp_pkg::*;
#(
  parameter int MODS = 16,
  parameter int CH   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scan_rst,
  input  logic [1:0]              scan_cfg,
  input  logic                    word_done,
  output logic [$clog2(CH)-1:0]   ana_sel,
  output logic [MODS-1:0]         ana_en,
  output logic [$clog2(MODS)-1:0] ana_mod,
  output logic [$clog2(MODS):0]   mod_lim
);

  localparam int CHW  = $clog2(CH);
  localparam int MODW = $clog2(MODS);

  logic [1:0]      cfg_q, cfg_n;
  logic [CHW-1:0]  ch_q, ch_n;
  logic [MODW-1:0] mod_q, mod_n;
  logic [MODW:0]   lim;

  always_comb begin
    lim   = (MODW + 1)'(scan_limit(cfg_q, MODS));
    cfg_n = cfg_q;
    ch_n  = ch_q;
    mod_n = mod_q;
    if (scan_rst) begin
      cfg_n = scan_cfg;
      ch_n  = '0;
      mod_n = '0;
    end else if (word_done) begin
      if (ch_q == CHW'(CH - 1)) begin
        ch_n  = '0;
        mod_n = ({1'b0, mod_q} == (lim - 1'b1)) ? '0 : MODW'(mod_q + 1'b1);
      end else begin
        ch_n = CHW'(ch_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 2'b11;
      ch_q  <= '0;
      mod_q <= '0;
    end else begin
      cfg_q <= cfg_n;
      ch_q  <= ch_n;
      mod_q <= mod_n;
    end
  end

  for (genvar g = 0; g < MODS; g++) begin : g_en
    assign ana_en[g] = (mod_q == MODW'(g));
  end

  assign ana_sel = ch_q;
  assign ana_mod = mod_q;
  assign mod_lim = lim;

endmodule

// File: rtl/spi_mux_expander.sv
module spi_mux_expander
  import pxp_pkg::*;
#(
  parameter int MODS   = 16,
  parameter int CH     = 16,
  parameter int SETTLE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scan_rst,
  input  logic [1:0]             scan_cfg,
  input  logic                   spi_sclk,
  input  logic                   spi_cs_n,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  output logic [MODS-1:0]        dout_line,
  input  logic [MODS-1:0]        din_line,
  output logic [$clog2(CH)-1:0]  dig_sel,
  output logic [$clog2(CH)-1:0]  ana_sel,
  output logic [MODS-1:0]        ana_en
);

  localparam int MODW = $clog2(MODS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  word_evt_t       evt;
  logic [MODS-1:0] rx_word;
  logic            tx_load;
  logic [MODS-1:0] tx_data;
  logic            word_start, word_done;
  logic [MODW-1:0] ana_mod;
  logic [MODW:0]   mod_lim;

  pxp_spi_word #(.W(MODS)) u_spi (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso),
    .tx_load (tx_load),
    .tx_data (tx_data),
    .evt     (evt),
    .rx_word (rx_word)
  );

  pxp_dig_seq #(.W(MODS), .CH(CH), .SETTLE(SETTLE)) u_dig (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .scan_rst  (scan_rst),
    .evt       (evt),
    .rx_word   (rx_word),
    .din_line  (din_line),
    .dig_sel   (dig_sel),
    .dout_line (dout_line),
    .tx_load   (tx_load),
    .tx_data   (tx_data)
  );

  pxp_ana_seq #(.MODS(MODS), .CH(CH)) u_ana (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .scan_rst  (scan_rst),
    .scan_cfg  (scan_cfg),
    .word_done (evt.done),
    .ana_sel   (ana_sel),
    .ana_en    (ana_en),
    .ana_mod   (ana_mod),
    .mod_lim   (mod_lim)
  );

  assign word_start = evt.start;
  assign word_done  = evt.done;

endmodule

// File: rtl/pxp_checker.sv
module pxp_checker #(
  parameter int MODS = 16,
  parameter int CH   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    scan_rst,
  input logic                    word_start,
  input logic                    word_done,
  input logic [$clog2(CH)-1:0]   dig_sel,
  input logic [MODS-1:0]         dout_line,
  input logic [$clog2(CH)-1:0]   ana_sel,
  input logic [MODS-1:0]         ana_en,
  input logic [$clog2(MODS)-1:0] ana_mod,
  input logic [$clog2(MODS):0]   mod_lim
);

  localparam int CHW = $clog2(CH);

  // R3: the digital address moves only after a word start or scan reset
  a_r3_sel_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dig_sel) |-> ($past(word_start) || $past(scan_rst)));

  // R4: output commons change only on word boundaries or scan reset
  a_r4_dout_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_line) |-> ($past(word_start) || $past(word_done) || $past(scan_rst)));

  // R7: each completed word moves the analog channel by one
  a_r7_ana_step: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !scan_rst) |=> (ana_sel == CHW'($past(ana_sel) + 1'b1)));

  // R7: no word, no analog channel change
  a_r7_ana_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_done && !scan_rst) |=> $stable(ana_sel));

  // R9: exactly one analog module enabled
  a_r9_onehot_en: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ana_en) == 1);

  // R8, R10: the module index never reaches the configured limit
  a_r10_mod_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ana_mod} < mod_lim);

endmodule

bind spi_mux_expander pxp_checker #(.MODS(MODS), .CH(CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .scan_rst   (scan_rst),
  .word_start (word_start),
  .word_done  (word_done),
  .dig_sel    (dig_sel),
  .dout_line  (dout_line),
  .ana_sel    (ana_sel),
  .ana_en     (ana_en),
  .ana_mod    (ana_mod),
  .mod_lim    (mod_lim)
);

// File: tb/tb_spi_mux_expander.sv
module tb_spi_mux_expander;

  localparam int HALF = 4;  // system clocks per SPI clock phase

  logic        clk = 1'b0;
  logic        rst_n, scan_rst;
  logic [1:0]  scan_cfg;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic [15:0] dout_line, din_line, ana_en;
  logic [3:0]  dig_sel, ana_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  spi_mux_expander dut (
    .clk(clk), .rst_n(rst_n), .scan_rst(scan_rst), .scan_cfg(scan_cfg),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .dout_line(dout_line), .din_line(din_line),
    .dig_sel(dig_sel), .ana_sel(ana_sel), .ana_en(ana_en)
  );

  function automatic logic [15:0] din_fn(input logic [3:0] c);
    return {c, ~c, c, c} ^ 16'h3C5A;
  endfunction

  assign din_line = din_fn(dig_sel);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full-duplex transfer of nbits (16 = full word), MSB first, mode 0
  task automatic xfer(input logic [15:0] tx, output logic [15:0] rx, input int nbits);
    rx = '0;
    spi_cs_n = 1'b0;
    clks(16);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[15-i];
      clks(HALF);
      rx[15-i] = spi_miso;
      spi_sclk = 1'b1;
      clks(HALF);
      spi_sclk = 1'b0;
    end
    clks(HALF);
    spi_cs_n = 1'b1;
    clks(12);
  endtask

  task automatic pulse_scan_rst(input logic [1:0] cfg);
    scan_cfg = cfg;
    scan_rst = 1'b1;
    clks(2);
    scan_rst = 1'b0;
    clks(2);
  endtask

  task automatic t_reset;
    chk(dig_sel == 4'd0, "R12 dig_sel", 32'(dig_sel), 0);
    chk(dout_line == 16'd0, "R12 dout_line", 32'(dout_line), 0);
    chk(ana_sel == 4'd0, "R12 ana_sel", 32'(ana_sel), 0);
    chk(ana_en == 16'd1, "R12 ana_en", 32'(ana_en), 1);
  endtask

  // R1 R2 R3 R4: seventeen words, checking wrap of the channel address
  task automatic t_digital;
    logic [15:0] rx, w;
    for (int k = 0; k < 17; k++) begin
      w = 16'h1234 ^ 16'(k * 16'h0F1D);
      xfer(w, rx, 16);
      chk(dig_sel == 4'(k % 16), "R3 address", 32'(dig_sel), 32'(k % 16));
      chk(rx == din_fn(4'(k % 16)), "R2 returned word", 32'(rx), 32'(din_fn(4'(k % 16))));
      chk(dout_line == w, "R1 R4 output word", 32'(dout_line), 32'(w));
    end
  endtask

  // R4 R5: blanking at start, abort leaves the channel unchanged
  task automatic t_abort;
    logic [15:0] rx;
    spi_cs_n = 1'b0;
    clks(10);
    chk(dout_line == 16'd0, "R4 blank on start", 32'(dout_line), 0);
    spi_cs_n = 1'b1;
    clks(12);
    xfer(16'hFFFF, rx, 8);
    chk(dout_line == 16'd0, "R5 no load on abort", 32'(dout_line), 0);
    xfer(16'hBEEF, rx, 16);
    chk(dig_sel == 4'd1, "R5 channel kept", 32'(dig_sel), 1);
    chk(rx == din_fn(4'd1), "R5 returned word", 32'(rx), 32'(din_fn(4'd1)));
    chk(dout_line == 16'hBEEF, "R5 output word", 32'(dout_line), 32'hBEEF);
  endtask

  // R6: scan reset mid-sequence
  task automatic t_scan_reset;
    logic [15:0] rx;
    xfer(16'h0001, rx, 16);
    xfer(16'h0002, rx, 16);
    pulse_scan_rst(2'd3);
    chk(dout_line == 16'd0, "R6 dout cleared", 32'(dout_line), 0);
    chk(ana_sel == 4'd0, "R6 ana cleared", 32'(ana_sel), 0);
    xfer(16'hA0A0, rx, 16);
    chk(dig_sel == 4'd0, "R6 channel 0", 32'(dig_sel), 0);
    chk(rx == din_fn(4'd0), "R6 returned ch0", 32'(rx), 32'(din_fn(4'd0)));
  endtask

  // R7 R8 R9 R10 R11: analog scan for one configuration
  task automatic t_analog(input logic [1:0] cfg);
    logic [15:0] rx;
    int lim, tot;
    lim = (int'(cfg) + 1) * 4;
    pulse_scan_rst(cfg);
    scan_cfg = ~cfg;  // R11: ignored outside scan reset
    chk(ana_en == 16'd1, "R10 start module", 32'(ana_en), 1);
    tot = lim * 16 + 16;
    for (int n = 1; n <= tot; n++) begin
      xfer(16'(n), rx, 16);
      chk(ana_sel == 4'(n % 16), "R7 analog channel", 32'(ana_sel), 32'(n % 16));
      chk(ana_en == (16'd1 << ((n / 16) % lim)), "R8 R9 R10 R11 module enable",
          32'(ana_en), 32'(16'd1 << ((n / 16) % lim)));
    end
  endtask

  initial begin
    rst_n = 1'b0; scan_rst = 1'b0; scan_cfg = 2'd0;
    spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    clks(5);
    rst_n = 1'b1;
    clks(5);
    t_reset();
    t_digital();
    t_abort();
    t_scan_reset();
    for (int c = 0; c < 4; c++) t_analog(2'(c));
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule